// File: doc/BRIEF.md
# GF(2^163) Multiplicative Inverter

This block returns the multiplicative inverse of an element of the binary field GF(2^163). The element is held in polynomial basis, and the field is defined by the reduction polynomial x^163 + x^7 + x^6 + x^3 + 1. Bit i of a value is the coefficient of x^i. The inverse is found as a^(2^163 - 2). The block first builds a^(2^162 - 1) along the addition chain 1, 2, 4, 8, 16, 32, 64, 128, 160, 162 and then squares that value once.

The datapath has two units, and every step of the chain shares them. The first is a digit-serial multiplier that takes 16 bits of one operand per clock, with a pipeline register between its partial-product stage and its accumulator. The second is a registered squarer that makes one pass per request. A pass raises its input either to the 16th power (four squarings) or to the square. A long run of squarings therefore advances four at a time. A client pulses `start` with the operand while the block is idle, sees `busy` go high for the run, and takes `result` when `done` pulses.

Top module: `gf_inverter`

## Requirements
- R1: When `start` is high while `busy` is low, the operand is captured at that clock edge and `busy` is high from the next cycle.
- R2: For a nonzero operand, `result` equals the inverse under the polynomial x^163 + x^7 + x^6 + x^3 + 1, with bit i holding the coefficient of x^i.
- R3: For a nonzero operand, the field product of the operand and `result` is the element 1, that is, only bit 0 is set.
- R4: A zero operand produces a zero `result`, with no other indication.
- R5: `done` is high for exactly one cycle per accepted operation, and `busy` is low in that cycle.
- R6: `start` pulses while `busy` is high are ignored. The running operation completes with its own operand, and no extra `done` is produced.
- R7: While `busy` is low, `result` keeps the last value produced, whatever `start` and `operand` do when no new run begins.
- R8: The number of cycles from an accepted `start` to `done` is the same for every operand value.
- R9: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to invert `operand`; acted on only when idle |
| operand | input | 163 | Field element to invert |
| busy | output | 1 | High while an inversion is running |
| done | output | 1 | One-cycle pulse marking `result` as new |
| result | output | 163 | Inverse of the last accepted operand |

## Verification
The operands are chosen to separate kinds of fault. The element 1 has no terms to reduce, so its inverse is itself. The element x has an inverse whose bits come almost entirely from the reduction taps. The element with only bit 162 set drives the top of every reduction loop. The all-ones element and random elements exercise dense carry-less products in every digit position. Zero is fed in to confirm the defined zero output. A `start` pulse in the middle of a run, carrying a different operand, shows whether the controller re-latches while busy. Comparing run lengths across all operands exposes any data-dependent sequencing.

// File: rtl/itinv_pkg.sv
package itinv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SQ_GO,
    ST_SQ_WAIT,
    ST_MUL_GO,
    ST_MUL_WAIT
  } inv_state_e;

  // Chain for exponent 162: 1,2,4,8,16,32,64,128,160,162, then one squaring.
  localparam int unsigned LAST_STEP = 9;

  // Squarings applied before the multiply of each step; step 9 is the final square.
  function automatic int unsigned step_shift(input int unsigned s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      4: return 16;
      5: return 32;
      6: return 64;
      7: return 32;
      8: return 2;
      default: return 1;
    endcase
  endfunction

endpackage

// File: rtl/gf_sqr_pow.sv
module gf_sqr_pow #(
  parameter int M = 163,
  parameter int K = 4,
  parameter logic [M-1:0] POLY = M'(8'hC9)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic         wide,
  input  logic [M-1:0] x,
  output logic         vld,
  output logic [M-1:0] y
);

  function automatic logic [M-1:0] sq1(input logic [M-1:0] v);
    logic [2*M-2:0] w;
    w = '0;
    for (int i = 0; i < M; i++) w[2*i] = v[i];
    for (int i = 2*M-2; i >= M; i--) begin
      if (w[i]) begin
        w[i-M +: M] = w[i-M +: M] ^ POLY;
        w[i] = 1'b0;
      end
    end
    return w[M-1:0];
  endfunction

  logic [M-1:0] stg [0:K];
  assign stg[0] = x;

  for (genvar g = 0; g < K; g++) begin : g_chain
    assign stg[g+1] = sq1(stg[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= 1'b0;
      y   <= '0;
    end else begin
      vld <= go;
      if (go) y <= wide ? stg[K] : stg[1];
    end
  end

endmodule

// File: rtl/gf_mul_digit.sv
module gf_mul_digit #(
  parameter int M = 163,
  parameter int D = 16,
  parameter logic [M-1:0] POLY = M'(8'hC9)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic         done,
  output logic [M-1:0] prod
);

  localparam int ND = (M + D - 1) / D;
  localparam int BW = ND * D;
  localparam int CW = $clog2(ND + 1);

  function automatic logic [M+D-2:0] clmul(input logic [M-1:0] av, input logic [D-1:0] d);
    logic [M+D-2:0] p;
    p = '0;
    for (int i = 0; i < D; i++)
      if (d[i]) p = p ^ ((M+D-1)'(av) << i);
    return p;
  endfunction

  function automatic logic [M-1:0] fold(input logic [M-1:0] acc, input logic [M+D-2:0] part);
    logic [M+D-1:0] w;
    w = {acc, {D{1'b0}}} ^ (M+D)'(part);
    for (int i = M+D-1; i >= M; i--) begin
      if (w[i]) begin
        w[i-M +: M] = w[i-M +: M] ^ POLY;
        w[i] = 1'b0;
      end
    end
    return w[M-1:0];
  endfunction

  logic [M-1:0]   a_r;
  logic [BW-1:0]  b_r;
  logic [CW-1:0]  cnt;
  logic           run;
  logic [M+D-2:0] part_r;
  logic           part_v, part_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_r <= '0; b_r <= '0; cnt <= '0; run <= 1'b0;
      part_r <= '0; part_v <= 1'b0; part_last <= 1'b0;
      prod <= '0; done <= 1'b0;
    end else begin
      part_v <= 1'b0;
      done   <= 1'b0;
      if (go) begin
        a_r  <= a;
        b_r  <= BW'(b);
        cnt  <= '0;
        run  <= 1'b1;
        prod <= '0;
      end else if (run) begin
        part_r    <= clmul(a_r, b_r[BW-1 -: D]);
        part_v    <= 1'b1;
        part_last <= (cnt == CW'(ND-1));
        b_r       <= b_r << D;
        cnt       <= cnt + 1'b1;
        if (cnt == CW'(ND-1)) run <= 1'b0;
      end
      if (part_v) begin
        prod <= fold(prod, part_r);
        if (part_last) done <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/gf_inverter.sv
module gf_inverter
  import itinv_pkg::*;
#(
  parameter int M = 163,
  parameter int D = 16,
  parameter int K = 4,
  parameter logic [M-1:0] POLY = M'(8'hC9)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] operand,
  output logic         busy,
  output logic         done,
  output logic [M-1:0] result
);

  localparam int RW = $clog2(M);
  localparam int SW = $clog2(LAST_STEP + 1);

  inv_state_e    state;
  logic [M-1:0]  t_r, keep_r, b2_r, b32_r;
  logic [RW-1:0] rem;
  logic [SW-1:0] step;
  logic          sq_go, sq_wide, sq_vld, mul_go, mul_done;
  logic [M-1:0]  sq_y, mul_p, mul_b;

  always_comb begin
    case (step)
      SW'(7):  mul_b = b32_r;
      SW'(8):  mul_b = b2_r;
      default: mul_b = keep_r;
    endcase
  end

  gf_sqr_pow #(.M(M), .K(K), .POLY(POLY)) u_sqr (
    .clk(clk), .rst(rst), .go(sq_go), .wide(sq_wide),
    .x(t_r), .vld(sq_vld), .y(sq_y)
  );

  gf_mul_digit #(.M(M), .D(D), .POLY(POLY)) u_mul (
    .clk(clk), .rst(rst), .go(mul_go), .a(t_r), .b(mul_b),
    .done(mul_done), .prod(mul_p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      busy <= 1'b0; done <= 1'b0; result <= '0;
      t_r <= '0; keep_r <= '0; b2_r <= '0; b32_r <= '0;
      rem <= '0; step <= '0;
      sq_go <= 1'b0; sq_wide <= 1'b0; mul_go <= 1'b0;
    end else begin
      done   <= 1'b0;
      sq_go  <= 1'b0;
      mul_go <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          t_r    <= operand;
          keep_r <= operand;
          step   <= '0;
          rem    <= RW'(step_shift(0));
          busy   <= 1'b1;
          state  <= ST_SQ_GO;
        end
        ST_SQ_GO: begin
          sq_go   <= 1'b1;
          sq_wide <= (rem >= RW'(K));
          rem     <= (rem >= RW'(K)) ? rem - RW'(K) : rem - 1'b1;
          state   <= ST_SQ_WAIT;
        end
        ST_SQ_WAIT: if (sq_vld) begin
          t_r <= sq_y;
          if (rem != '0) state <= ST_SQ_GO;
          else if (step == SW'(LAST_STEP)) begin
            result <= sq_y;
            done   <= 1'b1;
            busy   <= 1'b0;
            state  <= ST_IDLE;
          end else state <= ST_MUL_GO;
        end
        ST_MUL_GO: begin
          mul_go <= 1'b1;
          state  <= ST_MUL_WAIT;
        end
        ST_MUL_WAIT: if (mul_done) begin
          t_r    <= mul_p;
          keep_r <= mul_p;
          if (step == SW'(0)) b2_r  <= mul_p;
          if (step == SW'(4)) b32_r <= mul_p;
          step  <= step + 1'b1;
          rem   <= RW'(step_shift(int'(step) + 1));
          state <= ST_SQ_GO;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/gf_inverter_chk.sv
module gf_inverter_chk #(
  parameter int M = 163
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [M-1:0] result
);

  p_start_busy_r1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_end_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(result));

endmodule

bind gf_inverter gf_inverter_chk #(.M(M)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .result(result)
);

// File: tb/gf_inverter_test.sv
module gf_inverter_test;

  localparam int M = 163;
  localparam logic [M-1:0] POLY_L = M'(8'hC9);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [M-1:0] operand = '0;
  logic         busy, done;
  logic [M-1:0] result;

  gf_inverter uut (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .busy(busy), .done(done), .result(result)
  );

  always #10 clk = ~clk;

  int           n_chk = 0, n_fail = 0;
  logic [M-1:0] exp_q[$], op_q[$];
  longint       cyc = 0, t_start = 0, lat_ref = -1;
  logic [M-1:0] last_exp = '0;
  bit           prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
    logic [M-1:0] r;
    logic top;
    r = '0;
    for (int i = M-1; i >= 0; i--) begin
      top = r[M-1];
      r = r << 1;
      if (top) r = r ^ POLY_L;
      if (b[i]) r = r ^ a;
    end
    return r;
  endfunction

  function automatic logic [M-1:0] ref_inv(input logic [M-1:0] a);
    logic [M-1:0] s, acc;
    s = a;
    acc = M'(1);
    for (int i = 1; i < M; i++) begin
      s = ref_mul(s, s);
      acc = ref_mul(acc, s);
    end
    return acc;
  endfunction

  function automatic logic [M-1:0] rnd_elem();
    logic [191:0] w;
    w = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    return w[M-1:0];
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [M-1:0] act, input logic [M-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // Monitor: pops the scoreboard on every done pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_done) check(!done, "R5 done longer than one cycle", M'(done), '0);
      if (done) begin
        check(!busy, "R5 busy low with done", M'(busy), '0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected done", result, '0);
        end else begin
          logic [M-1:0] e, o;
          e = exp_q.pop_front();
          o = op_q.pop_front();
          last_exp = e;
          if (o == '0) check(result == '0, "R4 zero operand", result, '0);
          else begin
            check(result == e, "R2 inverse value", result, e);
            check(ref_mul(o, result) == M'(1), "R3 product is one", ref_mul(o, result), M'(1));
          end
          if (lat_ref < 0) lat_ref = cyc - t_start;
          else check((cyc - t_start) == lat_ref, "R8 latency",
                     M'(cyc - t_start), M'(lat_ref));
        end
      end
      prev_done = done;
    end
  end

  task automatic issue(input logic [M-1:0] a);
    @(negedge clk);
    start   = 1'b1;
    operand = a;
    exp_q.push_back(ref_inv(a));
    op_q.push_back(a);
    t_start = cyc;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R1 busy after start", M'(busy), M'(1));
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy || exp_q.size() != 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R9 reset flags", M'({busy, done}), '0);
    check(result == '0, "R9 reset result", result, '0);

    issue(M'(1));                 wait_idle();
    issue(M'(2));                 wait_idle();
    issue(M'(1) << (M-1));        wait_idle();
    issue({M{1'b1}});             wait_idle();
    issue('0);                    wait_idle();
    for (int i = 0; i < 5; i++) begin
      issue(rnd_elem());
      wait_idle();
    end

    // R6: start while busy with a different operand must be ignored.
    issue(rnd_elem());
    repeat (20) @(negedge clk);
    start = 1'b1;
    operand = rnd_elem();
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R6 still busy", M'(busy), M'(1));
    wait_idle();
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R6 no extra result", M'(exp_q.size()), '0);

    // R7: result holds while idle and operand changes.
    operand = rnd_elem();
    repeat (6) @(negedge clk);
    check(result == last_exp, "R7 result held", result, last_exp);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule